// File: doc/BRIEF.md
# Interrupt Status and Mask Controller

This block collects interrupt requests from up to sixteen peripheral sources and presents one interrupt line to the CPU. Each source raises a one-cycle pulse on its own request line. The pulse sets a sticky bit in a 16-bit status register. A 16-bit mask register selects which pending bits may reach the CPU. The CPU line is asserted while any bit is both pending and enabled.

Software reaches both registers through a simple synchronous register port. The port takes 16-bit or 32-bit accesses. Only the lower half of the data bus is significant on writes, and reads return zero in the upper half.

An acknowledge write to the status register keeps only the bits that are one in the written value and also enabled in the current mask. Pending bits that are masked off are therefore dropped rather than held. A write to the mask register that enables an already pending bit raises a one-cycle check pulse, so the CPU side can re-evaluate at once. Source index 3 is the one a DMA engine conventionally drives.

Top module: `irq_stat_mask_ctrl`

## Requirements
- R1: Synchronous active-low reset clears the status register, the mask register, `cpu_irq`, `irq_check` and `bus_rdata`.
- R2: A pulse on `src_pulse[i]` sets status bit i at the next clock edge. The bit then stays set until an acknowledge write clears it.
- R3: A write to offset 0x70 sets the status register to (status AND mask AND `bus_wdata[15:0]`). Writing 0 to a bit acknowledges it, and any pending bit that is masked off is cleared.
- R4: When a source pulse and an acknowledge write arrive in the same cycle, the status bit of that source is set after the edge.
- R5: A write to offset 0x74 replaces the mask register with `bus_wdata[15:0]`.
- R6: `cpu_irq` is a register output equal to the OR of (status AND mask) as held after each edge, so it changes in the same cycle as the registers.
- R7: `irq_check` is high for exactly the one cycle after a mask write whose new mask shares a set bit with the status value of that edge. It is low at all other times.
- R8: `bus_wdata[31:16]` has no effect on either register, and reads return zero in `bus_rdata[31:16]`.
- R9: A read with `bus_rd` high returns the pre-edge status (offset 0x70) or mask (offset 0x74) in `bus_rdata` the cycle after. Any other offset reads as zero and ignores writes. `bus_rdata` is zero in cycles after no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_pulse | input | 16 | One-cycle request pulses, one per source |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Byte offset within the I/O window |
| bus_wdata | input | 32 | Write data; only bits 15:0 used |
| bus_rdata | output | 32 | Registered read data |
| cpu_irq | output | 1 | CPU interrupt request |
| irq_check | output | 1 | One-cycle pulse after a mask write that enables a pending bit |

## Verification
The hardest case to reach is a source pulse that lands in the very cycle of an acknowledge write for the same bit. A close second is a mask write that enables a bit that is already pending. Random stimulus reaches both only rarely, because pulses are sparse. The bench therefore drives each of them as a directed step. It then runs a long random phase with dense pulses and frequent acknowledge and mask writes. In that phase every cycle is compared against a bench model.

// File: rtl/irq_ctrl_pkg.sv
// Package irq_ctrl_pkg
// Shared sizes, register offsets and decoded-command types for the
// interrupt status and mask controller.
package irq_ctrl_pkg;
    localparam int unsigned NUM_SRC = 16;
    localparam int unsigned ADDR_W  = 8;
    localparam int unsigned DATA_W  = 32;
    localparam logic [ADDR_W-1:0] STAT_OFS = 8'h70;
    localparam logic [ADDR_W-1:0] MASK_OFS = 8'h74;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_STAT = 2'd1,
        SEL_MASK = 2'd2
    } reg_sel_e;

    typedef struct packed {
        logic     stat_wr;
        logic     mask_wr;
        reg_sel_e rd_sel;
    } bus_cmd_t;
endpackage

// File: rtl/irq_reg_decode.sv
// Module irq_reg_decode
// Turns a bus strobe and byte offset into per-register write enables and a
// read selector. Assumes full-offset matching; unknown offsets decode to none.
module irq_reg_decode
    import irq_ctrl_pkg::*;
#(
    parameter int unsigned AW = ADDR_W,
    parameter logic [AW-1:0] STAT_ADDR = STAT_OFS,
    parameter logic [AW-1:0] MASK_ADDR = MASK_OFS
) (
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [AW-1:0] bus_addr,
    output bus_cmd_t      cmd
);
    logic hit_stat;
    logic hit_mask;

    // Address match for each register
    always_comb begin
        hit_stat = (bus_addr == STAT_ADDR);
        hit_mask = (bus_addr == MASK_ADDR);
    end

    // Build the command from the strobes and matches
    always_comb begin
        cmd.stat_wr = bus_wr && hit_stat;
        cmd.mask_wr = bus_wr && hit_mask;
        if (bus_rd && hit_stat)
            cmd.rd_sel = SEL_STAT;
        else if (bus_rd && hit_mask)
            cmd.rd_sel = SEL_MASK;
        else
            cmd.rd_sel = SEL_NONE;
    end
endmodule

// File: rtl/irq_status_reg.sv
// Module irq_status_reg
// Holds the sticky pending bits. A source pulse sets its bit. An acknowledge
// write keeps a bit only when it is set, enabled and written as one.
// A pulse in the acknowledge cycle wins. Assumes pulses are one cycle wide.
module irq_status_reg #(
    parameter int unsigned N = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] src_pulse,
    input  logic         ack_wr,
    input  logic [N-1:0] ack_val,
    input  logic [N-1:0] mask_q,
    output logic [N-1:0] status_q,
    output logic [N-1:0] status_d
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        logic keep;

        // Decide whether the held bit survives this cycle
        always_comb begin
            keep = ack_wr ? (status_q[i] & mask_q[i] & ack_val[i]) : status_q[i];
            status_d[i] = src_pulse[i] | keep;
        end

        // Store the next value of this bit
        always_ff @(posedge clk) begin
            if (!rst_n)
                status_q[i] <= 1'b0;
            else
                status_q[i] <= status_d[i];
        end
    end
endmodule

// File: rtl/irq_mask_reg.sv
// Module irq_mask_reg
// Holds the enable mask and produces a one-cycle check pulse when a mask
// write enables a bit that is pending after the same edge.
module irq_mask_reg #(
    parameter int unsigned N = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         mask_wr,
    input  logic [N-1:0] wr_val,
    input  logic [N-1:0] status_d,
    output logic [N-1:0] mask_q,
    output logic [N-1:0] mask_d,
    output logic         check_pulse
);
    // Next mask value
    always_comb begin
        mask_d = mask_wr ? wr_val : mask_q;
    end

    // Mask storage
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_q <= '0;
        else
            mask_q <= mask_d;
    end

    // Check pulse after an enabling mask write
    always_ff @(posedge clk) begin
        if (!rst_n)
            check_pulse <= 1'b0;
        else
            check_pulse <= mask_wr && (|(status_d & wr_val));
    end
endmodule

// File: rtl/irq_stat_mask_ctrl.sv
// Module irq_stat_mask_ctrl
// Top of the interrupt status and mask controller. Decodes the register
// port and keeps the status and mask registers. It drives a registered CPU
// request and registered read data. Assumes one access per cycle and
// ignores the upper half of write data.
module irq_stat_mask_ctrl
    import irq_ctrl_pkg::*;
#(
    parameter int unsigned NUM_SRC_P = NUM_SRC,
    parameter int unsigned ADDR_W_P  = ADDR_W,
    parameter int unsigned DATA_W_P  = DATA_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SRC_P-1:0] src_pulse,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [ADDR_W_P-1:0]  bus_addr,
    input  logic [DATA_W_P-1:0]  bus_wdata,
    output logic [DATA_W_P-1:0]  bus_rdata,
    output logic                 cpu_irq,
    output logic                 irq_check
);
    localparam int unsigned PAD_W = DATA_W_P - NUM_SRC_P;

    bus_cmd_t               cmd;
    logic [NUM_SRC_P-1:0]   wr_low;
    logic [NUM_SRC_P-1:0]   status_q;
    logic [NUM_SRC_P-1:0]   status_d;
    logic [NUM_SRC_P-1:0]   mask_q;
    logic [NUM_SRC_P-1:0]   mask_d;
    logic [PAD_W-1:0]       unused_wdata_hi;
    logic [DATA_W_P-1:0]    rd_next;

    // Split write data into used and ignored halves
    always_comb begin
        wr_low          = bus_wdata[NUM_SRC_P-1:0];
        unused_wdata_hi = bus_wdata[DATA_W_P-1:NUM_SRC_P];
    end

    irq_reg_decode #(
        .AW(ADDR_W_P)
    ) dec_i (
        .bus_wr  (bus_wr),
        .bus_rd  (bus_rd),
        .bus_addr(bus_addr),
        .cmd     (cmd)
    );

    irq_status_reg #(
        .N(NUM_SRC_P)
    ) stat_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_pulse(src_pulse),
        .ack_wr   (cmd.stat_wr),
        .ack_val  (wr_low),
        .mask_q   (mask_q),
        .status_q (status_q),
        .status_d (status_d)
    );

    irq_mask_reg #(
        .N(NUM_SRC_P)
    ) mask_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .mask_wr    (cmd.mask_wr),
        .wr_val     (wr_low),
        .status_d   (status_d),
        .mask_q     (mask_q),
        .mask_d     (mask_d),
        .check_pulse(irq_check)
    );

    // Registered CPU request from the next-state registers
    always_ff @(posedge clk) begin
        if (!rst_n)
            cpu_irq <= 1'b0;
        else
            cpu_irq <= |(status_d & mask_d);
    end

    // Select read data, zero-extended
    always_comb begin
        unique case (cmd.rd_sel)
            SEL_STAT: rd_next = {{PAD_W{1'b0}}, status_q};
            SEL_MASK: rd_next = {{PAD_W{1'b0}}, mask_q};
            default:  rd_next = '0;
        endcase
    end

    // Read data register
    always_ff @(posedge clk) begin
        if (!rst_n)
            bus_rdata <= '0;
        else
            bus_rdata <= rd_next;
    end
endmodule

// File: rtl/irq_ctrl_chk.sv
// Module irq_ctrl_chk
// Temporal checks on the controller, attached to every instance by bind.
module irq_ctrl_chk #(
    parameter int unsigned NUM_SRC_P = 16,
    parameter int unsigned ADDR_W_P  = 8,
    parameter int unsigned DATA_W_P  = 32
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_SRC_P-1:0] src_pulse,
    input logic                 bus_wr,
    input logic [ADDR_W_P-1:0]  bus_addr,
    input logic [DATA_W_P-1:0]  bus_wdata,
    input logic                 cpu_irq,
    input logic                 irq_check,
    input logic [NUM_SRC_P-1:0] status_q,
    input logic [NUM_SRC_P-1:0] mask_q
);
    logic stat_w;
    logic mask_w;

    // Writes seen at the port
    always_comb begin
        stat_w = bus_wr && (bus_addr == 8'h70);
        mask_w = bus_wr && (bus_addr == 8'h74);
    end

    AST_PULSE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (|src_pulse) |=> ((status_q & $past(src_pulse)) == $past(src_pulse))); // R2
    AST_ACK_WINS_NOT: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_w && (src_pulse == '0)) |=>
            (status_q == ($past(status_q) & $past(mask_q) & $past(bus_wdata[NUM_SRC_P-1:0])))); // R3
    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (!stat_w) |=> ((status_q & $past(status_q)) == $past(status_q))); // R2
    AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        mask_w |=> (mask_q == $past(bus_wdata[NUM_SRC_P-1:0]))); // R5
    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!mask_w) |=> $stable(mask_q)); // R5
    AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_irq == (|(status_q & mask_q))); // R6
    AST_CHECK_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_check |-> $past(mask_w)); // R7
endmodule

bind irq_stat_mask_ctrl irq_ctrl_chk #(
    .NUM_SRC_P(NUM_SRC_P),
    .ADDR_W_P (ADDR_W_P),
    .DATA_W_P (DATA_W_P)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_pulse(src_pulse),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .cpu_irq  (cpu_irq),
    .irq_check(irq_check),
    .status_q (status_q),
    .mask_q   (mask_q)
);

// File: tb/irq_stat_mask_ctrl_tb_top.sv
module irq_stat_mask_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] src_pulse = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        cpu_irq;
    logic        irq_check;

    int checks = 0;
    int errors = 0;
    logic done = 1'b0;

    logic [15:0] m_stat = '0;
    logic [15:0] m_mask = '0;

    always #4 clk = ~clk;

    irq_stat_mask_ctrl dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_pulse(src_pulse),
        .bus_wr   (bus_wr),
        .bus_rd   (bus_rd),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .cpu_irq  (cpu_irq),
        .irq_check(irq_check)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] next_stat(input logic [15:0] s, input logic [15:0] m,
                                              input logic [15:0] p, input logic ack,
                                              input logic [15:0] v);
        return p | (ack ? (s & m & v) : s);
    endfunction

    function automatic logic [31:0] read_val(input logic [7:0] a, input logic [15:0] s,
                                             input logic [15:0] m);
        if (a == 8'h70) return {16'h0, s};
        if (a == 8'h74) return {16'h0, m};
        return 32'h0;
    endfunction

    // One clock with model comparison of every output
    task automatic step(input logic [15:0] p, input logic wr, input logic rd,
                        input logic [7:0] a, input logic [31:0] d);
        logic [31:0] exp_rd;
        logic        exp_chk;
        @(negedge clk);
        src_pulse = p; bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d;
        exp_rd = rd ? read_val(a, m_stat, m_mask) : 32'h0;
        m_stat = next_stat(m_stat, m_mask, p, wr && a == 8'h70, d[15:0]);
        if (wr && a == 8'h74) m_mask = d[15:0];
        exp_chk = wr && a == 8'h74 && |(m_stat & d[15:0]);
        @(posedge clk);
        #1;
        src_pulse = '0; bus_wr = 1'b0; bus_rd = 1'b0;
        check("R6 cpu_irq", {31'h0, cpu_irq}, {31'h0, |(m_stat & m_mask)});
        check("R7 irq_check", {31'h0, irq_check}, {31'h0, exp_chk});
        check("R9 rdata", bus_rdata, exp_rd);
    endtask

    task automatic read_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
        step('0, 1'b0, 1'b1, a, '0);
        check(tag, bus_rdata, exp);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 cpu_irq", {31'h0, cpu_irq}, 32'h0);
        check("R1 irq_check", {31'h0, irq_check}, 32'h0);
        check("R1 rdata", bus_rdata, 32'h0);
        @(negedge clk); rst_n = 1'b1;
        read_chk("R1 status", 8'h70, 32'h0);
        read_chk("R1 mask", 8'h74, 32'h0);

        step('0, 1'b1, 1'b0, 8'h74, 32'h0000_0009);
        check("R7 no pending", {31'h0, irq_check}, 32'h0);
        read_chk("R5 mask", 8'h74, 32'h0000_0009);
        step(16'h0008, 1'b0, 1'b0, 8'h0, 32'h0);
        check("R6 enabled pending", {31'h0, cpu_irq}, 32'h1);
        read_chk("R2 status", 8'h70, 32'h0000_0008);
        step(16'h0010, 1'b0, 1'b0, 8'h0, 32'h0);
        read_chk("R2 sticky masked", 8'h70, 32'h0000_0018);
        step('0, 1'b1, 1'b0, 8'h70, 32'h0000_FFFF);
        read_chk("R3 masked discarded", 8'h70, 32'h0000_0008);
        step(16'h0008, 1'b1, 1'b0, 8'h70, 32'h0000_FFF7);
        read_chk("R4 pulse wins", 8'h70, 32'h0000_0008);
        step('0, 1'b1, 1'b0, 8'h70, 32'h0000_FFF7);
        read_chk("R3 ack zero", 8'h70, 32'h0);
        check("R6 idle", {31'h0, cpu_irq}, 32'h0);
        step(16'h0100, 1'b0, 1'b0, 8'h0, 32'h0);
        check("R6 masked pending", {31'h0, cpu_irq}, 32'h0);
        step('0, 1'b1, 1'b0, 8'h74, 32'h0000_0100);
        check("R7 enabling write", {31'h0, irq_check}, 32'h1);
        check("R6 after enable", {31'h0, cpu_irq}, 32'h1);
        step('0, 1'b0, 1'b0, 8'h0, 32'h0);
        check("R7 single cycle", {31'h0, irq_check}, 32'h0);
        step('0, 1'b1, 1'b0, 8'h74, 32'hABCD_0000);
        read_chk("R8 upper ignored", 8'h74, 32'h0);
        step('0, 1'b1, 1'b0, 8'h70, 32'hFFFF_0000);
        read_chk("R8 upper read zero", 8'h70, 32'h0);
        step('0, 1'b1, 1'b0, 8'h78, 32'h0000_FFFF);
        read_chk("R9 other offset", 8'h78, 32'h0);
        read_chk("R9 mask untouched", 8'h74, 32'h0);

        void'($urandom(32'd1234));
        for (int i = 0; i < 3000; i++) begin
            logic [15:0] p;
            logic [2:0]  op;
            logic [7:0]  a;
            logic [31:0] d;
            p  = (($urandom % 4) == 0) ? 16'(1 << ($urandom % 16)) : 16'h0;
            op = 3'($urandom % 8);
            d  = $urandom;
            if (($urandom % 2) == 0) d[15:0] = ~p;
            unique case (op)
                3'd0, 3'd1: a = 8'h70;
                3'd2:       a = 8'h74;
                3'd3:       a = 8'h72;
                default:    a = (($urandom % 2) == 0) ? 8'h70 : 8'h74;
            endcase
            step(p, op <= 3'd3, op >= 3'd3, a, d);
        end
        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (200000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule